// File: doc/BRIEF.md
# Buffered Block Program Sequencer

This block runs the data phase of a fast, buffered programming mode that fills one array block. When `start` is pulsed, the block is selected from the upper bits of `start_addr` and the first word position is taken from its lower bits. The host then loads a write buffer of `BUF_DEPTH` words through a simple write port. When the buffer is full, the sequencer copies it into the array one word at a time. It reads back every word it writes and compares it with the buffer copy. When the copy is done, it reports that the buffer can be loaded again.

The array position is kept between buffers. Each new buffer therefore continues from the word after the last one written. This lets the host program a whole block as a run of fill-and-program rounds. To leave the mode, the host writes the all-ones data word to any address outside the selected block. A status byte reports three things: the buffer is busy, a sticky program error, and the device is ready.

Top module: `bufprog_seq`

## Requirements
- R1: After reset, `status` reads 0x80: bit 7 (ready) is set and every other bit is clear. No array write takes place while reset is held.
- R2: After `start` is accepted, `status` reads 0x00 when no error is pending: bit 7 is 0 while the mode is active, and bit 0 is 0 while the buffer accepts data.
- R3: A write to any address inside the block loads the next buffer slot. The write that fills slot `BUF_DEPTH-1` sets status bit 0 from the next cycle on. Bit 0 stays 1 for exactly two cycles per buffered word, then returns to 0. Bit 0 and bit 7 are never 1 together.
- R4: The buffered words are written to the array in the order they were loaded, one array write every other cycle. The first word goes to the start offset, and each later word goes to the next higher address. Words on either side of the programmed range are not touched.
- R5: The array position carries over between buffers: buffer n+1 starts at the word after the last word of buffer n.
- R6: While status bit 0 is 1, bus writes inside the block are ignored. They change neither the buffer contents nor the fill position.
- R7: If a word read back from the array differs from the buffered word, status bit 4 is set. Bit 4 stays set until `err_clr` is pulsed, and then reads 0.
- R8: If the array position passes the last word of the block, programming stops and no write lands outside the block. Status bit 4 is set and the mode ends, so `status` reads 0x90.
- R9: While the buffer is ready, writing data 0xFFFF to an address outside the block ends the mode, and bit 7 reads 1 from the next cycle on. A write outside the block with any other data is ignored. 0xFFFF written inside the block is stored as an ordinary data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Enter the mode (taken only when ready) |
| start_addr | input | ADDR_W | Selected block (upper bits) and first word offset (lower bits) |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_data | input | DATA_W | Bus write data |
| err_clr | input | 1 | Clears the sticky program-error bit |
| status | output | 8 | Bit 7 ready, bit 4 program error, bit 0 buffer busy |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array word address (write and read-back) |
| arr_wdata | output | DATA_W | Array write data |
| arr_rdata | input | DATA_W | Array read data for the address on `arr_addr`, combinational |

## Verification
The assertions assume three things about the environment. `start` arrives only while bit 7 is set. `err_clr` is a pulse. The array returns, on the same cycle, the value at `arr_addr` as last written. The bench keeps to these assumptions: its memory model has a combinational read port, it pulses `start` only after reset or after an exit, and it drives every input on the falling clock edge for one full cycle. It flips one bit on a chosen write to force a read-back mismatch, which exercises the error path without breaking the timing assumption.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_PROG   = 2'd2,
    ST_VERIFY = 2'd3
  } seq_st_e;
endpackage

// File: rtl/bufprog_wbuf.sv
// Word buffer: one write port, one combinational read port.
module bufprog_wbuf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/bufprog_ctr.sv
// Up counter with clear (highest priority), load and increment.
module bufprog_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         en;

  assign en = clr || ld || inc;

  always_comb begin
    if (clr)     q_d = '0;
    else if (ld) q_d = ld_val;
    else         q_d = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_d;
  end
endmodule

// File: rtl/bufprog_seq.sv
module bufprog_seq
  import bufprog_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 12,
  parameter int BLK_W     = 8,
  parameter int BUF_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              err_clr,
  output logic [7:0]        status,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [DATA_W-1:0] arr_rdata
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int TAG_W = ADDR_W - BLK_W;
  localparam int OFF_W = BLK_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  seq_st_e           state_q, state_d;
  logic [TAG_W-1:0]  blk_q;
  logic              err_q, err_d;
  logic [IDX_W-1:0]  idx_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] buf_rd;

  logic in_blk, start_acc, fill_acc, exit_req, last_idx, overrun, mismatch;
  logic step, idx_clr;

  assign in_blk    = (bus_addr[ADDR_W-1:BLK_W] == blk_q);
  assign start_acc = (state_q == ST_IDLE) && start;
  assign fill_acc  = (state_q == ST_FILL) && bus_wr && in_blk;
  assign exit_req  = (state_q == ST_FILL) && bus_wr && !in_blk && (bus_data == '1);
  assign last_idx  = (idx_q == IDX_W'(BUF_DEPTH - 1));
  assign overrun   = (state_q == ST_PROG) && off_q[BLK_W];
  assign step      = (state_q == ST_VERIFY);
  assign mismatch  = step && (arr_rdata != buf_rd);
  assign idx_clr   = start_acc || overrun || ((fill_acc || step) && last_idx);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_FILL;
      ST_FILL: begin
        if (exit_req)                  state_d = ST_IDLE;
        else if (fill_acc && last_idx) state_d = ST_PROG;
      end
      ST_PROG:   state_d = overrun  ? ST_IDLE : ST_VERIFY;
      ST_VERIFY: state_d = last_idx ? ST_FILL : ST_PROG;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign err_d = (err_q && !err_clr) || mismatch || overrun;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       blk_q <= '0;
    else if (start_acc) blk_q <= start_addr[ADDR_W-1:BLK_W];
  end

  bufprog_ctr #(.W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_i_n), .clr(idx_clr), .ld(1'b0), .ld_val('0),
    .inc(fill_acc || step), .q(idx_q)
  );

  bufprog_ctr #(.W(OFF_W)) u_off (
    .clk(clk), .rst_n(rst_i_n), .clr(1'b0), .ld(start_acc),
    .ld_val({1'b0, start_addr[BLK_W-1:0]}), .inc(step), .q(off_q)
  );

  bufprog_wbuf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_wbuf (
    .clk(clk), .wr_en(fill_acc), .wr_idx(idx_q), .wr_data(bus_data),
    .rd_idx(idx_q), .rd_data(buf_rd)
  );

  assign arr_we    = (state_q == ST_PROG) && !off_q[BLK_W];
  assign arr_addr  = {blk_q, off_q[BLK_W-1:0]};
  assign arr_wdata = buf_rd;

  assign status = {(state_q == ST_IDLE), 2'b00, err_q, 3'b000,
                   (state_q == ST_PROG) || (state_q == ST_VERIFY)};
endmodule

// File: rtl/bufprog_chk.sv
module bufprog_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int BLK_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        status,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              err_clr,
  input logic [ADDR_W-BLK_W-1:0] blk
);
  p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> !status[7]);

  p_we_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> status[0]);

  p_we_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we);

  p_we_in_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_addr[ADDR_W-1:BLK_W] == blk));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !err_clr) |=> status[4]);

  p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[7] && !status[0] && bus_wr && (bus_data == '1) &&
     (bus_addr[ADDR_W-1:BLK_W] != blk)) |=> status[7]);
endmodule

bind bufprog_seq bufprog_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .arr_we(arr_we), .arr_addr(arr_addr),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data), .err_clr(err_clr),
  .blk(blk_q)
);

// File: tb/bufprog_seq_test.sv
module bufprog_seq_test;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int BW = 8;
  localparam int ND = 32;

  logic          clk, rst_n, start, bus_wr, err_clr;
  logic [AW-1:0] start_addr, bus_addr, arr_addr;
  logic [DW-1:0] bus_data, arr_wdata, arr_rdata;
  logic [7:0]    status;
  logic          arr_we;

  int n_chk = 0;
  int n_fail = 0;
  int we_cnt = 0;
  logic          flip_en;
  logic [AW-1:0] flip_addr;
  logic [DW-1:0] mem [1 << AW];

  bufprog_seq #(.DATA_W(DW), .ADDR_W(AW), .BLK_W(BW), .BUF_DEPTH(ND)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data), .err_clr(err_clr),
    .status(status), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural array with optional single-bit corruption
  always @(posedge clk) begin
    if (arr_we) begin
      we_cnt <= we_cnt + 1;
      mem[arr_addr] <= (flip_en && arr_addr == flip_addr) ? (arr_wdata ^ 16'h0001) : arr_wdata;
    end
  end
  assign arr_rdata = mem[arr_addr];

  // rows: offset, buffer count, inject error, expect error
  localparam logic [31:0] VEC [4] = '{
    {8'd0,   8'd1, 8'd0, 8'd0},
    {8'd32,  8'd2, 8'd0, 8'd0},
    {8'd224, 8'd1, 8'd0, 8'd0},
    {8'd100, 8'd3, 8'd1, 8'd1}
  };

  function automatic logic [DW-1:0] dv(int r, int n);
    return DW'((r * 16'h1111) ^ (n * 16'h0101 + 16'h0033));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
  endtask

  task automatic bwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_start(input logic [AW-1:0] a);
    @(negedge clk);
    start = 1'b1; start_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && status[0]; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0; bus_wr = 1'b0;
    bus_addr = '0; bus_data = '0; err_clr = 1'b0; flip_en = 1'b0; flip_addr = '0;
    clear_mem();
    repeat (4) @(negedge clk);
    chk(we_cnt == 0, "R1 no write in reset", we_cnt, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(status == 8'h80, "R1 reset status", status, 8'h80);

    // table walk
    for (int r = 0; r < 4; r++) begin
      int off, nb, base, bad, first;
      bit inj, xerr;
      off = int'(VEC[r][31:24]); nb = int'(VEC[r][23:16]);
      inj = VEC[r][8]; xerr = VEC[r][0];
      base = (r + 1) << BW;
      clear_mem();
      flip_en = inj; flip_addr = AW'(base + off + 5);
      do_start(AW'(base + off));
      chk(status == 8'h00, "R2 mode entered", status, 8'h00);
      for (int b = 0; b < nb; b++) begin
        for (int k = 0; k < ND; k++) bwrite(AW'(base + k), dv(r, b * ND + k));
        wait_idle();
      end
      chk(status == {3'b000, xerr, 4'b0000}, "R7 R3 status after buffers", status, {3'b000, xerr, 4'b0000});
      bad = 0; first = -1;
      for (int j = 0; j < nb * ND; j++) begin
        logic [DW-1:0] e;
        e = dv(r, j);
        if (inj && j == 5) e = e ^ 16'h0001;
        if (mem[base + off + j] != e) begin
          bad++;
          if (first < 0) first = j;
        end
      end
      chk(bad == 0, "R4 R5 array contents", first, -1);
      if (off > 0) chk(mem[base + off - 1] == 0, "R4 word below untouched", mem[base + off - 1], 0);
      if (off + nb * ND < (1 << BW))
        chk(mem[base + off + nb * ND] == 0, "R4 word above untouched", mem[base + off + nb * ND], 0);
      bwrite(AW'(0), 16'hFFFF);
      chk(status == {1'b1, 2'b00, xerr, 4'b0000}, "R9 exit status", status, {1'b1, 2'b00, xerr, 4'b0000});
      pulse_clr();
      chk(status == 8'h80, "R7 error cleared", status, 8'h80);
    end
    flip_en = 1'b0;

    // busy length, ignored writes, exit-pattern handling
    begin
      int base, cnt;
      base = 5 << BW;
      clear_mem();
      do_start(AW'(base));
      for (int k = 0; k < ND - 1; k++) bwrite(AW'(base), dv(7, k));
      chk(status[0] == 1'b0, "R3 not busy before last word", status, 0);
      bwrite(AW'(base), dv(7, ND - 1));
      cnt = 0;
      while (status[0] && cnt < 500) begin cnt++; @(negedge clk); end
      chk(cnt == 2 * ND, "R3 busy duration", cnt, 2 * ND);
      for (int k = 0; k < ND; k++) bwrite(AW'(base + 3), dv(8, k));
      bwrite(AW'(base), 16'hDEAD);
      bwrite(AW'(base + 1), 16'hBEEF);
      wait_idle();
      chk(mem[base + ND] == dv(8, 0) && mem[base + 2 * ND - 1] == dv(8, ND - 1),
          "R6 R5 second buffer intact", mem[base + ND], dv(8, 0));
      bwrite(AW'(0), 16'h1234);
      chk(status == 8'h00, "R9 other data outside ignored", status, 8'h00);
      bwrite(AW'(base), 16'hFFFF);
      for (int k = 1; k < ND - 1; k++) bwrite(AW'(base), dv(9, k));
      chk(status[0] == 1'b0, "R6 fill position unchanged", status, 0);
      bwrite(AW'(base), dv(9, ND - 1));
      chk(status[0] == 1'b1, "R6 programming at slot end", status, 1);
      wait_idle();
      chk(mem[base + 2 * ND] == 16'hFFFF, "R9 inside all-ones stored", mem[base + 2 * ND], 16'hFFFF);
      chk(mem[base + 3 * ND - 1] == dv(9, ND - 1), "R6 third buffer last word", mem[base + 3 * ND - 1], dv(9, ND - 1));
      bwrite(AW'(0), 16'hFFFF);
      chk(status == 8'h80, "R9 exit after buffers", status, 8'h80);
    end

    // overrun past block end
    begin
      int base;
      base = 6 << BW;
      clear_mem();
      do_start(AW'(base + 240));
      for (int k = 0; k < ND; k++) bwrite(AW'(base), dv(10, k));
      wait_idle();
      chk(status == 8'h90, "R8 overrun status", status, 8'h90);
      chk(mem[base + 255] == dv(10, 15), "R8 last in-block word", mem[base + 255], dv(10, 15));
      chk(mem[base + 256] == 0, "R8 next block untouched", mem[base + 256], 0);
      pulse_clr();
      chk(status == 8'h80, "R7 clear after overrun", status, 8'h80);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule